// File: doc/BRIEF.md
# Bus-Activity Supervisory Watchdog

This block supervises a host by watching its serial peripheral bus. Each new select of the bus, seen as a falling edge on the active-low chip-select line, counts as proof that the host is alive and restarts an idle counter. If the counter reaches the selected timeout, the block drives a reset pulse of fixed minimum width. It then starts counting again from zero, so a host that stays silent gets a fresh pulse once every timeout.

The timeout comes from a 2-bit field that lives in the part's status register at bit positions 4 (high) and 3 (low). Three codes pick a period and the fourth turns the watchdog off. A digital low-supply flag from an external detector is synchronized and ORed into the same reset output. The detector is not part of this block. Periods and the pulse width are clock-cycle counts set by parameters.

Top module: `bus_watchdog`

## Requirements
- R1: While rst_ni is low, and afterwards until a timeout or low supply occurs, rst_o is low.
- R2: When cs_ni goes from high to low and is first sampled low at rising clock edge n, the idle count restarts at edge n+2. With no further activity and an enabled code, rst_o rises right after edge n+2+L, where L is the selected period in cycles.
- R3: The wd_sel_i code (bit 1 = status bit 4, bit 0 = status bit 3) maps as follows: 00 gives SLOW_CYC, 01 gives MID_CYC, 10 gives FAST_CYC, and 11 disables the watchdog.
- R4: A second falling edge before the timeout restarts the count. The timeout is then measured from that edge's restart point.
- R5: Only falling edges count as activity. Holding cs_ni low does not keep restarting the count.
- R6: A watchdog pulse keeps rst_o high for exactly PULSE_CYC cycles. The count then restarts from zero, so an idle bus yields a pulse every L+PULSE_CYC cycles.
- R7: With code 11 held, the watchdog never asserts rst_o, however long the bus stays idle.
- R8: A change of wd_sel_i restarts the count at the first clock edge that samples the new code. The new period applies from that point.
- R9: low_supply_i sampled high at edge m drives rst_o high from edge m+1 onward, regardless of wd_sel_i. rst_o returns low one edge after low_supply_i is first sampled low, unless a watchdog pulse is active.
- R10: Bus activity during a reset pulse is ignored. The pulse keeps its full width, and the next count starts from the pulse's end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Bus chip select, active low, asynchronous to clk_i |
| wd_sel_i | input | 2 | Timeout code from the status register |
| low_supply_i | input | 1 | Low-supply flag from an external detector, active high |
| rst_o | output | 1 | Supervisory reset, active high |

## Verification
The bench checks the exact edge at which the pulse rises relative to a falling chip select. A design that loses or adds a synchronizer stage would shift that edge by a cycle, and one that decodes the code bits in the wrong order would fire on the wrong period. Holding chip select low across a whole window catches a design that treats the level as activity, because that design would never fire. A kick landing inside a pulse catches one that shortens or restarts the pulse. A code change part-way through a count catches a design that keeps the old count or the old period and so fires early. The low-supply path is driven with the watchdog disabled, which isolates its two-stage latency.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef enum logic [1:0] {
    WD_SLOW = 2'b00,
    WD_MID  = 2'b01,
    WD_FAST = 2'b10,
    WD_OFF  = 2'b11
  } wd_sel_e;

  typedef enum logic {
    WD_RUN  = 1'b0,
    WD_HOLD = 1'b1
  } wd_state_e;
endpackage

// File: rtl/wd_sync.sv
module wd_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wd_period_sel.sv
module wd_period_sel
  import wd_pkg::*;
#(
  parameter int SLOW_CYC = 14000,
  parameter int MID_CYC  = 6000,
  parameter int FAST_CYC = 2000,
  parameter int CW       = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] limit_o,
  output logic          en_o,
  output logic          chg_o
);
  logic [1:0] sel_q;

  // power-on value equals the off code, so a first enabled code restarts the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= WD_OFF;
    else         sel_q <= sel_i;
  end

  always_comb begin
    unique case (wd_sel_e'(sel_i))
      WD_SLOW: limit_o = CW'(SLOW_CYC);
      WD_MID:  limit_o = CW'(MID_CYC);
      WD_FAST: limit_o = CW'(FAST_CYC);
      WD_OFF:  limit_o = '0;
    endcase
  end

  assign en_o  = (wd_sel_e'(sel_i) != WD_OFF);
  assign chg_o = (sel_q != sel_i);
endmodule

// File: rtl/wd_timer.sv
module wd_timer
  import wd_pkg::*;
#(
  parameter int PULSE_CYC = 1000,
  parameter int CW        = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          pulse_o
);
  wd_state_e     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        WD_RUN: begin
          if (clr_i || !en_i) begin
            cnt_q <= '0;
          end else if (cnt_q == limit_i - CW'(1)) begin
            state_q <= WD_HOLD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        WD_HOLD: begin
          // minimum width: activity and code changes are not seen here
          if (cnt_q == CW'(PULSE_CYC - 1)) begin
            state_q <= WD_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      endcase
    end
  end

  assign pulse_o = (state_q == WD_HOLD);
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
  parameter int SLOW_CYC  = 14000,
  parameter int MID_CYC   = 6000,
  parameter int FAST_CYC  = 2000,
  parameter int PULSE_CYC = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic [1:0] wd_sel_i,
  input  logic       low_supply_i,
  output logic       rst_o
);
  localparam int MAX_A  = (SLOW_CYC > MID_CYC) ? SLOW_CYC : MID_CYC;
  localparam int MAX_B  = (FAST_CYC > PULSE_CYC) ? FAST_CYC : PULSE_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_C + 1);

  logic          cs_s, cs_d, kick;
  logic          lvd_s;
  logic [CW-1:0] limit;
  logic          wd_en, sel_chg, wd_pulse;

  wd_sync #(.RST_VAL(1'b1)) u_cs_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cs_ni),
    .q_o   (cs_s)
  );

  wd_sync #(.RST_VAL(1'b0)) u_lvd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (low_supply_i),
    .q_o   (lvd_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_d <= 1'b1;
    else         cs_d <= cs_s;
  end

  // new select only; a held-low select is not activity
  assign kick = cs_d & ~cs_s;

  wd_period_sel #(
    .SLOW_CYC(SLOW_CYC),
    .MID_CYC (MID_CYC),
    .FAST_CYC(FAST_CYC),
    .CW      (CW)
  ) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (wd_sel_i),
    .limit_o(limit),
    .en_o   (wd_en),
    .chg_o  (sel_chg)
  );

  wd_timer #(
    .PULSE_CYC(PULSE_CYC),
    .CW       (CW)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wd_en),
    .clr_i  (kick | sel_chg),
    .limit_i(limit),
    .pulse_o(wd_pulse)
  );

  assign rst_o = wd_pulse | lvd_s;
endmodule

// File: rtl/wd_chk.sv
module wd_chk #(
  parameter int SLOW_CYC  = 14000,
  parameter int MID_CYC   = 6000,
  parameter int FAST_CYC  = 2000,
  parameter int PULSE_CYC = 1000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] wd_sel_i,
  input logic       low_supply_i,
  input logic       rst_o,
  input logic       kick_i,
  input logic       pulse_i
);
  int unsigned idle_q, width_q, lim;
  logic [1:0]  age_q;
  logic [1:0]  sel_prev_q;

  always_comb begin
    case (wd_sel_i)
      2'b00:   lim = SLOW_CYC;
      2'b01:   lim = MID_CYC;
      2'b10:   lim = FAST_CYC;
      default: lim = 0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q     <= 0;
      width_q    <= 0;
      age_q      <= '0;
      sel_prev_q <= 2'b11;
    end else begin
      sel_prev_q <= wd_sel_i;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (kick_i || pulse_i || (sel_prev_q != wd_sel_i)) idle_q <= 0;
      else if (idle_q != 32'hFFFF_FFFF) idle_q <= idle_q + 1;
      if (pulse_i) width_q <= width_q + 1;
      else         width_q <= 0;
    end
  end

  // R2 R4 R8
  timeout_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> (idle_q == lim));

  // R6 R10
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_i) |-> (width_q == PULSE_CYC));

  // R7
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_sel_i == 2'b11 && $past(wd_sel_i) == 2'b11) |-> !$rose(pulse_i));

  // R9
  low_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(low_supply_i) && $past(low_supply_i, 2)) |-> rst_o);
endmodule

bind bus_watchdog wd_chk #(
  .SLOW_CYC (SLOW_CYC),
  .MID_CYC  (MID_CYC),
  .FAST_CYC (FAST_CYC),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wd_sel_i    (wd_sel_i),
  .low_supply_i(low_supply_i),
  .rst_o       (rst_o),
  .kick_i      (kick),
  .pulse_i     (wd_pulse)
);

// File: tb/sim_bus_watchdog.sv
module sim_bus_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int T_SLOW  = 60;
  localparam int T_MID   = 40;
  localparam int T_FAST  = 24;
  localparam int T_PULSE = 6;

  localparam int K_PLAIN = 0, K_KICK2 = 1, K_HELD = 2, K_SELCHG = 3, K_PKICK = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic [1:0] wd_sel = 2'b11;
  logic       low_supply = 1'b0;
  logic       rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_watchdog #(
    .SLOW_CYC (T_SLOW),
    .MID_CYC  (T_MID),
    .FAST_CYC (T_FAST),
    .PULSE_CYC(T_PULSE)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .wd_sel_i    (wd_sel),
    .low_supply_i(low_supply),
    .rst_o       (rst_o)
  );

  // R3 code map
  function automatic int lim_of(input logic [1:0] s);
    case (s)
      2'b00:   return T_SLOW;
      2'b01:   return T_MID;
      2'b10:   return T_FAST;
      default: return 0;
    endcase
  endfunction

  // expected rst_o after edge j, count restarted at edge c with period l
  function automatic bit exp_rst(input int j, input int c, input int l);
    int rel;
    if (l == 0) return 1'b0;
    rel = j - c;
    if (rel < l) return 1'b0;
    return ((rel - l) % (l + T_PULSE)) < T_PULSE;
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    while (rst_o) @(negedge clk);
    wd_sel = 2'b11;
    cs_ni  = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic trial(input int kind, input logic [1:0] s, input logic [1:0] s2, input int k);
    int c, l, win;
    string req;
    settle();
    wd_sel = s;
    cs_ni  = 1'b0;
    c = 2;
    l = lim_of(s);
    case (kind)
      K_KICK2:  begin c = k + 3; req = "R4"; end
      K_HELD:   req = "R5";
      K_SELCHG: begin c = k + 1; l = lim_of(s2); req = "R8"; end
      K_PKICK:  req = "R10";
      default:  req = (s == 2'b11) ? "R7" : "R2/R3/R6";
    endcase
    win = c + 2 * (l > 0 ? l : T_SLOW) + T_PULSE + 4;
    for (int j = 0; j < win; j++) begin
      @(negedge clk);
      check(req, rst_o, exp_rst(j, c, l));
      if (j == 0 && kind != K_HELD) cs_ni = 1'b1;
      if (kind == K_KICK2 && j == k) cs_ni = 1'b0;
      if (kind == K_KICK2 && j == k + 1) cs_ni = 1'b1;
      if (kind == K_SELCHG && j == k) wd_sel = s2;
      if (kind == K_PKICK && j == l + 3) cs_ni = 1'b0;
      if (kind == K_PKICK && j == l + 4) cs_ni = 1'b1;
    end
    cs_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, run hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", rst_o, 1'b0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", rst_o, 1'b0);

    // R2 R3 R6 each enabled code, and R7 disabled code
    trial(K_PLAIN, 2'b00, 2'b00, 0);
    trial(K_PLAIN, 2'b01, 2'b00, 0);
    trial(K_PLAIN, 2'b10, 2'b00, 0);
    trial(K_PLAIN, 2'b11, 2'b00, 0);
    // R5 held select
    trial(K_HELD, 2'b10, 2'b00, 0);
    // R4 kick just before timeout
    trial(K_KICK2, 2'b10, 2'b00, T_FAST - 1);
    // R8 switch from fast to slow late in the count
    trial(K_SELCHG, 2'b10, 2'b00, T_FAST);
    // R8 switch to disabled
    trial(K_SELCHG, 2'b01, 2'b11, 10);
    // R10 kick inside the pulse
    trial(K_PKICK, 2'b10, 2'b00, 0);

    // R9 low supply with watchdog off
    settle();
    low_supply = 1'b1;
    @(negedge clk);
    check("R9", rst_o, 1'b0);
    @(negedge clk);
    check("R9", rst_o, 1'b1);
    repeat (4) @(negedge clk);
    check("R9", rst_o, 1'b1);
    low_supply = 1'b0;
    @(negedge clk);
    check("R9", rst_o, 1'b1);
    @(negedge clk);
    check("R9", rst_o, 1'b0);

    // random mix
    for (int t = 0; t < 30; t++) begin
      int kind;
      logic [1:0] s, s2;
      int k, l1;
      kind = $urandom_range(0, 4);
      s  = 2'($urandom_range(0, 2));
      s2 = 2'($urandom_range(0, 3));
      l1 = lim_of(s);
      k  = $urandom_range(2, l1 - 1);
      if (kind == K_SELCHG && s2 == s) s2 = 2'b11;
      if (kind == K_PLAIN && $urandom_range(0, 3) == 0) s = 2'b11;
      trial(kind, s, s2, k);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule